// File: doc/BRIEF.md
# Programmable asynchronous serial transceiver

This block is a full-duplex asynchronous serial port for a processor that talks to it through two 8-bit registers: a data register and a status register. A single select input picks which of the two is addressed. Writing the data register hands one character to the transmitter. Reading the data register returns the last character received. The status register reports whether the transmitter can take another character and whether a received character is waiting, along with its error flags. Writing any value to the status register acknowledges the received character.

The framing is set at run time through configuration inputs. The character length can be 5, 6, 7 or 8 bits. Parity can be off, even or odd. The stop period can be 1, 1.5 or 2 bit times. A 16-bit divisor sets the rate of a 16x oversampling tick, so every bit lasts 16 ticks. The transmitter has one holding register in front of its shift engine, which lets software queue the next character while the current one is still on the line. The receiver confirms a start bit at mid-bit, samples each bit at its centre and flags parity, framing and overrun errors. A request line is high while a received character is waiting.

Top module: `sio_port`

## Requirements
- R1: After reset the status register reads 0x01 (only transmit-ready set), the serial output is high and the request line is low.
- R2: A transmitted frame is one low start bit, then the data bits least significant first, then the optional parity bit, then a high stop period. The line is high between frames. The number of data bits is 5 + cfg_len (cfg_len = 0..3), and every start, data and parity bit lasts 16 ticks.
- R3: With cfg_par_en = 1, a parity bit follows the data. With cfg_par_odd = 0 (even), the total count of ones in the data plus parity is even. With cfg_par_odd = 1 (odd), that count is odd.
- R4: The stop period lasts 16 ticks for cfg_stop = 0, 24 ticks for cfg_stop = 1, and 32 ticks for cfg_stop = 2 or 3.
- R5: Status bit 0 (transmit-ready) is 1 exactly when the holding register is empty. A data write made while it is 0 is ignored: that character is never sent.
- R6: If a character is waiting when a stop period ends, its start bit begins on the tick that ends that stop period. The start-to-start spacing is then exactly the frame length in ticks, with no idle time between frames.
- R7: A received frame sets status bit 1 (receive-ready) and raises the request line. The data register (select = 0) returns the character in the low bits, with the unused upper bits read as 0.
- R8: Status bit 2 (parity error) is set when parity is enabled and the received parity bit does not match the selected sense.
- R9: Status bit 3 (framing error) is set when the line is low at the centre of the stop bit.
- R10: Status bit 4 (overrun) is set when a character completes while receive-ready is still set. The new character replaces the old one in the data register.
- R11: A write to the status register (select = 1), whatever the value written, clears bits 1 to 4 and drops the request line. Bits 5 to 7 always read 0.
- R12: One tick occurs every cfg_div + 1 clock cycles, and all bit timing in both directions scales with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | 16 | Tick divisor: one tick every cfg_div+1 clocks |
| cfg_len | input | 2 | Character length code: 5 + cfg_len bits |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| cfg_stop | input | 2 | Stop length code: 0 one bit, 1 one and a half bits, 2 or 3 two bits |
| bus_sel | input | 1 | Register select: 0 data, 1 status |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| irq | output | 1 | Request line: high while a received character waits |

## Verification
A register write takes effect at the next clock edge, so the bench reads status one cycle after each write. An idle transmitter starts a frame on the next tick after a data write. From the detected falling edge, the bench samples bit k at k·16·(cfg_div+1) + 8·(cfg_div+1) clocks, which is the centre of each bit. It times R6 as the difference between the start edges of two queued frames. A received character becomes visible roughly half a bit into its stop period, after a two-stage input synchroniser, so the bench reads status only after it has driven the whole stop period plus idle time. It sweeps every combination of length, parity mode and stop length in both directions, and runs separate frames for each error flag and for a slower divisor.

// File: rtl/sio_pkg.sv
// Package: shared types and framing helpers for the serial transceiver.
// Assumes 16x oversampling and character lengths coded 0..3 for 5..8 bits.
package sio_pkg;

    localparam int OVS  = 16;
    localparam int HALF = OVS / 2;
    localparam int CNT_W = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic [1:0] stop;
    } frame_cfg_t;

    // Number of data bits for a length code.
    function automatic logic [3:0] char_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    // Stop period length in ticks for a stop code.
    function automatic logic [CNT_W-1:0] stop_ticks(input logic [1:0] s);
        case (s)
            2'd0:    return CNT_W'(OVS);
            2'd1:    return CNT_W'(OVS + HALF);
            default: return CNT_W'(2 * OVS);
        endcase
    endfunction

    // Mask of the valid data bits for a length code.
    function automatic logic [7:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

endpackage

// File: rtl/sio_tick.sv
// Module: oversampling tick generator.
// Emits a one-cycle tick every div+1 clocks. Assumes div is held steady
// while frames are in flight.
module sio_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // Count clocks and pulse the tick when the divisor is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= div) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    // R12: with a divisor above zero, a tick is never followed by another tick.
    p_tick_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick);

endmodule

// File: rtl/sio_tx.sv
// Module: transmitter with one holding register and a shift engine.
// Framing is latched when a character moves from the holding register
// into the engine; all phase changes happen on oversampling ticks.
module sio_tx
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              txd,
    output logic              ready
);

    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVS - 1);

    logic [DATA_W-1:0] hold_q;
    logic              hold_full;
    logic [DATA_W-1:0] sh_q;
    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [2:0]        idx_q;
    logic [3:0]        nbits_q;
    logic              par_en_q;
    logic              par_bit_q;
    logic [CNT_W-1:0]  stop_len_q;
    logic              stop_end;
    logic              take;

    assign stop_end = (phase_q == PH_STOP) && (cnt_q == stop_len_q - 1'b1);
    assign take     = tick && hold_full && ((phase_q == PH_IDLE) || stop_end);
    assign ready    = !hold_full;

    // Holding register: accept a write only when empty, release on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (take) begin
            hold_full <= 1'b0;
        end else if (wr_en && !hold_full) begin
            hold_q    <= wdata;
            hold_full <= 1'b1;
        end
    end

    // Shift engine: walk start, data, parity and stop phases on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            cnt_q      <= '0;
            idx_q      <= '0;
            sh_q       <= '0;
            nbits_q    <= 4'd8;
            par_en_q   <= 1'b0;
            par_bit_q  <= 1'b0;
            stop_len_q <= CNT_W'(OVS);
        end else if (tick) begin
            if (take) begin
                phase_q    <= PH_START;
                cnt_q      <= '0;
                idx_q      <= '0;
                sh_q       <= hold_q;
                nbits_q    <= char_bits(cfg.len);
                par_en_q   <= cfg.par_en;
                par_bit_q  <= (^(hold_q & len_mask(cfg.len))) ^ cfg.par_odd;
                stop_len_q <= stop_ticks(cfg.stop);
            end else begin
                case (phase_q)
                    PH_START: begin
                        if (cnt_q == BIT_LAST) begin
                            cnt_q   <= '0;
                            phase_q <= PH_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (cnt_q == BIT_LAST) begin
                            cnt_q <= '0;
                            sh_q  <= sh_q >> 1;
                            if ({1'b0, idx_q} == nbits_q - 4'd1) begin
                                phase_q <= par_en_q ? PH_PAR : PH_STOP;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_PAR: begin
                        if (cnt_q == BIT_LAST) begin
                            cnt_q   <= '0;
                            phase_q <= PH_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_STOP: begin
                        if (stop_end) begin
                            cnt_q   <= '0;
                            phase_q <= PH_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    // Line driver: select the level of the current phase.
    always_comb begin
        case (phase_q)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = sh_q[0];
            PH_PAR:   txd = par_bit_q;
            default:  txd = 1'b1;
        endcase
    end

    // R5: a write while the holding register is full leaves it unchanged.
    p_hold_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && wr_en) |=> (hold_q == $past(hold_q)));

    // R6: the holding register only empties on a tick.
    p_take_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_full) |-> $past(tick));

    // R2: the engine phase only moves on a tick.
    p_phase_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (phase_q == $past(phase_q)));

    // R4: the stop counter never runs past the latched stop length.
    p_stop_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STOP) |-> (cnt_q < stop_len_q));

endmodule

// File: rtl/sio_rx.sv
// Module: receiver with input synchroniser, bit sampler and status flags.
// Assumes the line idles high. Confirms the start bit at mid-bit and samples
// later bits at their centres; the framing in cfg must be steady per frame.
module sio_rx
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic              rxd,
    input  logic              ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              ready,
    output logic              perr,
    output logic              ferr,
    output logic              ovr
);

    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(HALF - 1);

    logic              sync1_q;
    logic              rx_s;
    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [2:0]        idx_q;
    logic [DATA_W-1:0] sh_q;
    logic              par_rx_q;
    logic              stop_ok_q;
    logic              fin_q;
    logic [3:0]        nbits;
    logic [DATA_W-1:0] assembled;
    logic              par_bad;

    assign nbits     = char_bits(cfg.len);
    assign assembled = sh_q >> (4'd8 - nbits);
    assign par_bad   = cfg.par_en && ((^assembled) ^ par_rx_q ^ cfg.par_odd);

    // Two-stage synchroniser for the asynchronous serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            sync1_q <= rxd;
            rx_s    <= sync1_q;
        end
    end

    // Frame sampler: find a start bit and sample each later bit at its centre.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            idx_q     <= '0;
            sh_q      <= '0;
            par_rx_q  <= 1'b0;
            stop_ok_q <= 1'b1;
            fin_q     <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (tick) begin
                case (phase_q)
                    PH_IDLE: begin
                        if (!rx_s) begin
                            phase_q <= PH_START;
                            cnt_q   <= '0;
                        end
                    end
                    PH_START: begin
                        if (cnt_q == MID_LAST) begin
                            cnt_q   <= '0;
                            idx_q   <= '0;
                            sh_q    <= '0;
                            phase_q <= rx_s ? PH_IDLE : PH_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (cnt_q == BIT_LAST) begin
                            cnt_q <= '0;
                            sh_q  <= {rx_s, sh_q[DATA_W-1:1]};
                            if ({1'b0, idx_q} == nbits - 4'd1) begin
                                phase_q <= cfg.par_en ? PH_PAR : PH_STOP;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_PAR: begin
                        if (cnt_q == BIT_LAST) begin
                            cnt_q    <= '0;
                            par_rx_q <= rx_s;
                            phase_q  <= PH_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_STOP: begin
                        if (cnt_q == BIT_LAST) begin
                            cnt_q     <= '0;
                            stop_ok_q <= rx_s;
                            fin_q     <= 1'b1;
                            phase_q   <= PH_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    // Status flags and data register: set on completion, cleared by ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            ready   <= 1'b0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
            ovr     <= 1'b0;
        end else if (fin_q) begin
            rx_data <= assembled;
            ready   <= 1'b1;
            perr    <= (perr && !ack) || par_bad;
            ferr    <= (ferr && !ack) || !stop_ok_q;
            ovr     <= (ovr && !ack) || (ready && !ack);
        end else if (ack) begin
            ready <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            ovr   <= 1'b0;
        end
    end

    // R10: overrun only rises while a character was already waiting.
    p_ovr_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(ready));

    // R11: an acknowledge with no completing frame clears ready and overrun.
    p_ack_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !fin_q) |=> (!ready && !ovr));

    // R7: a completed frame always leaves receive-ready set.
    p_ready_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |=> ready);

    // R9: framing error rises only on a completed frame.
    p_ferr_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ferr) |-> $past(fin_q));

endmodule

// File: rtl/sio_port.sv
// Module: top of the serial transceiver. Decodes the two-register bus,
// packs the configuration inputs and builds the status byte.
// Assumes configuration is changed only while the line is idle.
module sio_port
    import sio_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [1:0]        cfg_stop,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              txd,
    input  logic              rxd,
    output logic              irq
);

    localparam int FLAG_N = 5;

    frame_cfg_t        cfg;
    logic              tick;
    logic              tx_ready;
    logic              rx_ready;
    logic              rx_perr;
    logic              rx_ferr;
    logic              rx_ovr;
    logic [DATA_W-1:0] rx_data;
    logic              wr_data;
    logic              wr_status;
    logic [DATA_W-1:0] status;

    assign cfg       = '{len: cfg_len, par_en: cfg_par_en,
                         par_odd: cfg_par_odd, stop: cfg_stop};
    assign wr_data   = bus_wr && !bus_sel;
    assign wr_status = bus_wr && bus_sel;
    assign status    = {{(DATA_W-FLAG_N){1'b0}}, rx_ovr, rx_ferr, rx_perr,
                        rx_ready, tx_ready};
    assign bus_rdata = bus_sel ? status : rx_data;
    assign irq       = rx_ready;

    sio_tick #(.DIV_W(DIV_W)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (cfg_div),
        .tick  (tick)
    );

    sio_tx #(.DATA_W(DATA_W)) tx_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cfg   (cfg),
        .wr_en (wr_data),
        .wdata (bus_wdata),
        .txd   (txd),
        .ready (tx_ready)
    );

    sio_rx #(.DATA_W(DATA_W)) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cfg     (cfg),
        .rxd     (rxd),
        .ack     (wr_status),
        .rx_data (rx_data),
        .ready   (rx_ready),
        .perr    (rx_perr),
        .ferr    (rx_ferr),
        .ovr     (rx_ovr)
    );

    // R1: after reset the line is idle high and nothing is requested.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (txd && !irq && tx_ready));

endmodule

// File: tb/sio_port_tb.sv
// Bench: sweeps framing options in both directions and checks error flags.
module sio_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = '0;
    logic [1:0]  cfg_len = 2'd3;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic [1:0]  cfg_stop = 2'd0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        txd;
    logic        rxd = 1'b1;
    logic        irq;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    sio_port dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .txd(txd), .rxd(rxd), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int nbits(input logic [1:0] len);
        return 5 + int'(len);
    endfunction

    function automatic int stop_t(input logic [1:0] s);
        return (s == 2'd0) ? 16 : (s == 2'd1) ? 24 : 32;
    endfunction

    function automatic logic [7:0] mask(input logic [1:0] len);
        return 8'((1 << nbits(len)) - 1);
    endfunction

    function automatic logic par_of(input logic [7:0] d, input logic [1:0] len,
                                    input logic odd);
        return (^(d & mask(len))) ^ odd;
    endfunction

    task automatic bus_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic sel, output logic [7:0] v);
        @(negedge clk);
        bus_sel = sel;
        #1 v = bus_rdata;
    endtask

    // Capture one transmitted frame by sampling bit centres.
    task automatic tx_capture(input int d, output logic [7:0] data, output logic par,
                              output logic stop_lvl, output int start_cyc);
        int n;
        int pos;
        n = nbits(cfg_len);
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        start_cyc = cyc;
        pos = 0;
        data = '0;
        for (int k = 1; k <= n; k++) begin
            repeat (k*16*d + 8*d - pos) @(negedge clk);
            pos = k*16*d + 8*d;
            data[k-1] = txd;
        end
        par = 1'b0;
        if (cfg_par_en) begin
            repeat ((n+1)*16*d + 8*d - pos) @(negedge clk);
            pos = (n+1)*16*d + 8*d;
            par = txd;
        end
        repeat ((n+1+int'(cfg_par_en))*16*d + (stop_t(cfg_stop)/2)*d - pos) @(negedge clk);
        stop_lvl = txd;
    endtask

    // Drive one frame onto the serial input.
    task automatic rx_send(input logic [7:0] d, input int dv, input bit bad_par,
                           input bit bad_stop);
        int n;
        n = nbits(cfg_len);
        @(negedge clk);
        rxd = 1'b0;
        repeat (16*dv) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            rxd = d[k];
            repeat (16*dv) @(negedge clk);
        end
        if (cfg_par_en) begin
            rxd = par_of(d, cfg_len, cfg_par_odd) ^ bad_par;
            repeat (16*dv) @(negedge clk);
        end
        if (bad_stop) begin
            rxd = 1'b0;
            repeat (12*dv) @(negedge clk);
            rxd = 1'b1;
            repeat ((stop_t(cfg_stop) - 12)*dv) @(negedge clk);
        end else begin
            rxd = 1'b1;
            repeat (stop_t(cfg_stop)*dv) @(negedge clk);
        end
        repeat (64*dv) @(negedge clk);
    endtask

    // Send two queued characters and check both frames and their spacing.
    task automatic tx_pair(input logic [7:0] a, input logic [7:0] b, input int d,
                           input string tag);
        logic [7:0] da, db, st;
        logic pa, pb, sa, sb;
        int ca, cb;
        int n;
        n = nbits(cfg_len);
        fork
            begin
                tx_capture(d, da, pa, sa, ca);
                tx_capture(d, db, pb, sb, cb);
            end
            begin
                bus_write(1'b0, a);
                st = 8'h00;
                while (st[0] !== 1'b1) bus_read(1'b1, st);
                bus_write(1'b0, b);
            end
        join
        chk(da == (a & mask(cfg_len)), "R2", {tag, " data A"}, da, a & mask(cfg_len));
        chk(db == (b & mask(cfg_len)), "R2", {tag, " data B"}, db, b & mask(cfg_len));
        if (cfg_par_en) begin
            chk(pa == par_of(a, cfg_len, cfg_par_odd), "R3", {tag, " parity A"}, pa,
                par_of(a, cfg_len, cfg_par_odd));
            chk(pb == par_of(b, cfg_len, cfg_par_odd), "R3", {tag, " parity B"}, pb,
                par_of(b, cfg_len, cfg_par_odd));
        end
        chk(sa && sb, "R4", {tag, " stop level"}, {sa, sb}, 2'b11);
        chk(cb - ca == ((1 + n + int'(cfg_par_en))*16 + stop_t(cfg_stop))*d, "R6",
            {tag, " start spacing"}, cb - ca,
            ((1 + n + int'(cfg_par_en))*16 + stop_t(cfg_stop))*d);
        repeat (stop_t(cfg_stop)*d) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] a, b, c, got, stv;
        logic p, s;
        int cs;
        int lows;
        int idx;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        bus_read(1'b1, v);
        chk(v == 8'h01, "R1", "status after reset", v, 8'h01);
        chk(txd == 1'b1 && irq == 1'b0, "R1", "txd/irq after reset", {txd, irq}, 2'b10);

        // Transmit sweep over all framings at one tick per clock.
        idx = 0;
        for (int ln = 0; ln < 4; ln++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int sp = 0; sp < 3; sp++) begin
                    cfg_len = 2'(ln);
                    cfg_par_en = (pm != 0);
                    cfg_par_odd = (pm == 2);
                    cfg_stop = 2'(sp);
                    a = 8'(idx*37 + 11);
                    b = 8'(~(idx*53 + 5));
                    tx_pair(a, b, 1, $sformatf("tx len%0d pm%0d st%0d", ln, pm, sp));
                    idx++;
                end
            end
        end

        // Receive sweep over all framings.
        idx = 0;
        for (int ln = 0; ln < 4; ln++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int sp = 0; sp < 3; sp++) begin
                    cfg_len = 2'(ln);
                    cfg_par_en = (pm != 0);
                    cfg_par_odd = (pm == 2);
                    cfg_stop = 2'(sp);
                    a = 8'(idx*71 + 29);
                    rx_send(a, 1, 1'b0, 1'b0);
                    bus_read(1'b0, got);
                    chk(got == (a & mask(cfg_len)), "R7", "rx data", got, a & mask(cfg_len));
                    bus_read(1'b1, stv);
                    chk(stv == 8'h03 && irq, "R7", "rx status ready", {irq, stv}, 9'h103);
                    bus_write(1'b1, 8'hFF);
                    bus_read(1'b1, stv);
                    chk(stv == 8'h01 && !irq, "R11", "status after ack", {irq, stv}, 9'h001);
                    idx++;
                end
            end
        end

        // Parity error, even and odd sense.
        for (int od = 0; od < 2; od++) begin
            cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = od[0]; cfg_stop = 2'd0;
            rx_send(8'h5C, 1, 1'b1, 1'b0);
            bus_read(1'b1, stv);
            chk(stv == 8'h07, "R8", "parity error flag", stv, 8'h07);
            bus_write(1'b1, 8'h00);
            bus_read(1'b1, stv);
            chk(stv == 8'h01, "R11", "perr cleared", stv, 8'h01);
        end

        // Framing error.
        cfg_par_en = 1'b0; cfg_len = 2'd3; cfg_stop = 2'd0;
        rx_send(8'hC3, 1, 1'b0, 1'b1);
        bus_read(1'b1, stv);
        chk(stv == 8'h0B, "R9", "framing error flag", stv, 8'h0B);
        bus_write(1'b1, 8'h00);

        // Overrun: two characters without acknowledge.
        rx_send(8'h11, 1, 1'b0, 1'b0);
        rx_send(8'h22, 1, 1'b0, 1'b0);
        bus_read(1'b1, stv);
        chk(stv == 8'h13, "R10", "overrun flag", stv, 8'h13);
        bus_read(1'b0, got);
        chk(got == 8'h22, "R10", "overrun keeps newest", got, 8'h22);
        bus_write(1'b1, 8'h00);
        bus_read(1'b1, stv);
        chk(stv == 8'h01, "R11", "overrun cleared", stv, 8'h01);

        // Ignored write while holding register full.
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop = 2'd0;
        a = 8'h3C; b = 8'hA9; c = 8'h66;
        fork
            begin
                tx_capture(1, got, p, s, cs);
                chk(got == a, "R5", "first frame", got, a);
                tx_capture(1, got, p, s, cs);
                chk(got == b, "R5", "second frame not overwritten", got, b);
            end
            begin
                bus_write(1'b0, a);
                stv = 8'h00;
                while (stv[0] !== 1'b1) bus_read(1'b1, stv);
                bus_write(1'b0, b);
                bus_read(1'b1, stv);
                chk(stv[0] == 1'b0, "R5", "not ready while holding", stv[0], 0);
                bus_write(1'b0, c);
            end
        join
        lows = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        chk(lows == 0, "R5", "dropped write never sent", lows, 0);

        // Slower divisor in both directions.
        cfg_div = 16'd2;
        cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_stop = 2'd1; cfg_len = 2'd2;
        tx_pair(8'h4B, 8'h35, 3, "R12 tx div2");
        rx_send(8'h5A, 3, 1'b0, 1'b0);
        bus_read(1'b0, got);
        chk(got == 8'h5A, "R12", "rx data div2", got, 8'h5A);
        bus_read(1'b1, stv);
        chk(stv == 8'h03, "R12", "rx status div2", stv, 8'h03);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule